// File: doc/BRIEF.md
# Priority Interrupt Controller Command and Status Port

This block is an interrupt controller for up to eight request lines with fixed priority, line 0 highest. Rising edges on the request lines are latched into a pending register. A pending line that is not masked and not held off by work already in service is eligible, and the block raises `int_req` while any line is eligible. Software reaches the block over a byte-wide bus with one address bit. Address 0 is the command/status port and address 1 is the data port.

Writes to the command port carry three kinds of words. An initialization word has bit 4 set. An end-of-service word has bits 4:3 = 00. An operational word has bits 4:3 = 01 and bit 7 clear. The operational word does three things. It switches special mask mode, in which a level that is in service no longer holds off the levels below it. It arms a one-shot poll, after which the next bus read acknowledges the best eligible request. It chooses whether status reads show the pending register or the in-service register. The data port holds the mask register.

Top module: `irq_cmd_port`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, normal mask mode is active, no poll is armed, and command-port reads return the pending register.
- R2: A command-port write is taken as an operational word only when bit 7 = 0 and bits 4:3 = 01. A write with bit 7 = 1 changes nothing.
- R3: In an operational word, bits 1:0 = 10 selects the pending register and 11 selects the in-service register for command-port reads. The selection holds for any number of reads.
- R4: In an operational word, bits 1:0 = 00 or 01 leave the status read selection unchanged.
- R5: In an operational word with bit 5 = 1, bit 6 = 1 enters special mask mode and bit 6 = 0 returns to normal mask mode. With bit 5 = 0 the mode stays as it was, whatever bit 6 holds.
- R6: Bit 2 = 1 in an operational word arms a poll. The next read at either address returns 8'b1000_0LLL, where LLL is the lowest-numbered eligible line. That read sets the line's in-service bit, clears its pending bit and disarms the poll, so the read after it is a normal read.
- R7: A poll read with no eligible line returns 8'h00, changes neither the pending nor the in-service register, and disarms the poll.
- R8: In normal mask mode, a set in-service bit holds off its own line and every higher-numbered line.
- R9: In special mask mode, every pending unmasked line is eligible whatever the in-service register holds, so a lower-priority line can be serviced while a higher one is in service.
- R10: A command-port write with bits 4:3 = 00 and bits 7:5 = 011 clears the in-service bit named by bits 2:0. With bits 7:5 = 001 it clears the lowest-numbered set in-service bit.
- R11: Data-port writes load the mask register and data-port reads return it. A masked line is never eligible.
- R12: A command-port write with bit 4 = 1 clears the pending, in-service and mask registers, restores normal mask mode, disarms any poll and selects the pending register for status reads.
- R13: A pending bit is set on a rising edge of its request line, at the clock edge that samples the new level. `int_req` is high exactly while some line is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = command/status port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_in | input | N_LINES | Request lines, rising-edge sensitive |
| int_req | output | 1 | High while any line is eligible |

## Verification
A wrong status selection appears on the very next command-port read, because that read returns the other register. A mode bit that has gone stale appears on `int_req`. For example, a lower line held off or let through wrongly changes `int_req` one edge after that line's request rises. A poll flag that stays armed or fails to arm shows up on the next read: that read returns the acknowledge code in place of status, or status in place of the acknowledge code. The in-service register can then be read out to confirm which line was acknowledged.

// File: rtl/irq_cmd_pkg.sv
`timescale 1ns/1ps
package irq_cmd_pkg;

   localparam int BYTE_W = 8;
   localparam int LVL_FIELD_W = 3;

   typedef struct packed {
      logic                   init;
      logic                   op_word;
      logic                   eoi_spec;
      logic                   eoi_any;
      logic                   smm_en;
      logic                   smm_val;
      logic                   poll;
      logic                   sel_load;
      logic                   sel_isr;
      logic [LVL_FIELD_W-1:0] lvl;
   } cmd_t;

endpackage

// File: rtl/irq_cmd_decode.sv
`timescale 1ns/1ps
module irq_cmd_decode
   import irq_cmd_pkg::*;
(
   input  logic              valid,
   input  logic [BYTE_W-1:0] data,
   output cmd_t              cmd
);
   logic is_op, is_eoi;

   always_comb begin
      is_op  = valid && !data[7] && (data[4:3] == 2'b01);
      is_eoi = valid && (data[4:3] == 2'b00);
      cmd          = '0;
      cmd.init     = valid && data[4];
      cmd.op_word  = is_op;
      cmd.eoi_spec = is_eoi && (data[7:5] == 3'b011);
      cmd.eoi_any  = is_eoi && (data[7:5] == 3'b001);
      cmd.smm_en   = is_op && data[5];
      cmd.smm_val  = data[6];
      cmd.poll     = is_op && data[2];
      cmd.sel_load = is_op && data[1];
      cmd.sel_isr  = data[0];
      cmd.lvl      = data[2:0];
   end
endmodule

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch #(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_in,
   input  logic [N_LINES-1:0] clr_vec,
   input  logic               clr_all,
   output logic [N_LINES-1:0] irr
);
   logic [N_LINES-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr    <= '0;
      end else begin
         prev_q <= irq_in;
         if (clr_all) irr <= '0;
         else         irr <= (irr & ~clr_vec) | (irq_in & ~prev_q);
      end
   end
endmodule

// File: rtl/irq_prio_resolve.sv
`timescale 1ns/1ps
module irq_prio_resolve #(
   parameter int N_LINES = 8,
   localparam int LVL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic [N_LINES-1:0] irr,
   input  logic [N_LINES-1:0] isr,
   input  logic [N_LINES-1:0] mask,
   input  logic               special,
   output logic               any,
   output logic [LVL_W-1:0]   win_lvl,
   output logic [N_LINES-1:0] win_vec
);
   logic [N_LINES-1:0] held_normal;
   logic [N_LINES-1:0] held;
   logic [N_LINES-1:0] eligible;

   for (genvar i = 0; i < N_LINES; i++) begin : g_hold
      assign held_normal[i] = |isr[i:0];
   end

   assign held     = special ? (isr & mask) : held_normal;
   assign eligible = irr & ~mask & ~held;
   assign any      = |eligible;

   always_comb begin
      win_lvl = '0;
      win_vec = '0;
      for (int i = N_LINES - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            win_lvl = LVL_W'(i);
            win_vec = N_LINES'(1) << i;
         end
      end
   end
endmodule

// File: rtl/irq_cmd_port.sv
`timescale 1ns/1ps
module irq_cmd_port
   import irq_cmd_pkg::*;
#(
   parameter int N_LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [N_LINES-1:0] irq_in,
   output logic               int_req
);
   localparam int LVL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;
   localparam int PAD_W = BYTE_W - N_LINES;

   if (N_LINES < 2 || N_LINES > (1 << LVL_FIELD_W)) begin : g_bad_lines
      $error("irq_cmd_port: N_LINES must be between 2 and 8");
   end

   cmd_t               cmd;
   logic [N_LINES-1:0] irr, isr_q, mask_q, win_vec, irr_clr, isr_lowest;
   logic [LVL_W-1:0]   win_lvl;
   logic               any, poll_armed, sel_isr, smm_on, poll_hit;

   irq_cmd_decode u_dec (
      .valid (bus_wr && !bus_addr),
      .data  (bus_wdata),
      .cmd   (cmd)
   );

   irq_edge_latch #(.N_LINES(N_LINES)) u_irr (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .clr_vec (irr_clr),
      .clr_all (cmd.init),
      .irr     (irr)
   );

   irq_prio_resolve #(.N_LINES(N_LINES)) u_prio (
      .irr     (irr),
      .isr     (isr_q),
      .mask    (mask_q),
      .special (smm_on),
      .any     (any),
      .win_lvl (win_lvl),
      .win_vec (win_vec)
   );

   assign poll_hit = bus_rd && poll_armed;
   assign irr_clr  = (poll_hit && any) ? win_vec : '0;
   assign int_req  = any;

   always_comb begin
      isr_lowest = '0;
      for (int i = N_LINES - 1; i >= 0; i--)
         if (isr_q[i]) isr_lowest = N_LINES'(1) << i;
   end

   always_comb begin
      if (poll_hit)
         bus_rdata = any ? {1'b1, {(BYTE_W-1-LVL_FIELD_W){1'b0}}, LVL_FIELD_W'(win_lvl)} : '0;
      else if (!bus_addr)
         bus_rdata = {{PAD_W{1'b0}}, (sel_isr ? isr_q : irr)};
      else
         bus_rdata = {{PAD_W{1'b0}}, mask_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cmd.init) begin
         isr_q      <= '0;
         mask_q     <= '0;
         poll_armed <= 1'b0;
         sel_isr    <= 1'b0;
         smm_on     <= 1'b0;
      end else begin
         if (cmd.smm_en)   smm_on  <= cmd.smm_val;
         if (cmd.sel_load) sel_isr <= cmd.sel_isr;
         if (cmd.poll)     poll_armed <= 1'b1;
         else if (poll_hit) poll_armed <= 1'b0;
         if (bus_wr && bus_addr) mask_q <= bus_wdata[N_LINES-1:0];
         if (poll_hit && any) isr_q <= isr_q | win_vec;
         else if (cmd.eoi_any) isr_q <= isr_q & ~isr_lowest;
         else if (cmd.eoi_spec) begin
            for (int i = 0; i < N_LINES; i++)
               if (cmd.lvl == LVL_FIELD_W'(i)) isr_q[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_cmd_port_chk.sv
`timescale 1ns/1ps
module irq_cmd_port_chk #(
   parameter int N_LINES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_addr,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic               int_req,
   input logic               poll_armed,
   input logic               sel_isr,
   input logic               smm_on,
   input logic [N_LINES-1:0] isr_q
);
   logic op_wr;
   assign op_wr = bus_wr && !bus_addr && !bus_wdata[7] && (bus_wdata[4:3] == 2'b01);

   // R4
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !bus_wdata[1]) |=> $stable(sel_isr));

   // R5
   smm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !bus_wdata[5]) |=> $stable(smm_on));

   // R6
   poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && poll_armed && !bus_wr) |=> !poll_armed);

   // R6
   poll_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && poll_armed && int_req) |-> (bus_rdata[7] && bus_rdata[6:3] == 4'b0));

   // R7
   poll_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && poll_armed && !int_req) |-> (bus_rdata == 8'h00));

   // R8
   top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smm_on && isr_q[0]) |-> !int_req);
endmodule

bind irq_cmd_port irq_cmd_port_chk #(.N_LINES(N_LINES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .int_req    (int_req),
   .poll_armed (poll_armed),
   .sel_isr    (sel_isr),
   .smm_on     (smm_on),
   .isr_q      (isr_q)
);

// File: tb/irq_cmd_port_test.sv
`timescale 1ns/1ps
module irq_cmd_port_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_addr = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [7:0]   bus_wdata = '0;
   logic [7:0]   bus_rdata;
   logic [N-1:0] irq_in = '0;
   logic         int_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_cmd_port #(.N_LINES(N)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .int_req(int_req)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(tag, bus_rdata, exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic raise(input int line);
      @(negedge clk);
      irq_in[line] = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 int_req", {7'b0, int_req}, 8'h00);
      rd(1'b0, 8'h00, "R1 status");
      rd(1'b1, 8'h00, "R1 mask");
   endtask

   task automatic t_select_poll;
      raise(3);
      chk("R13 int_req", {7'b0, int_req}, 8'h01);
      rd(1'b0, 8'h08, "R1 default pending select");
      wr(1'b0, 8'h0C);
      rd(1'b0, 8'h83, "R6 poll ack");
      chk("R6 int_req after ack", {7'b0, int_req}, 8'h00);
      rd(1'b0, 8'h00, "R6 disarmed");
      wr(1'b0, 8'h0B);
      rd(1'b0, 8'h08, "R3 in-service");
      rd(1'b0, 8'h08, "R3 repeat");
      wr(1'b0, 8'h08);
      rd(1'b0, 8'h08, "R4 bits 00");
      wr(1'b0, 8'h09);
      rd(1'b0, 8'h08, "R4 bits 01");
      wr(1'b0, 8'h0A);
      rd(1'b0, 8'h00, "R3 pending");
   endtask

   task automatic t_normal_eoi;
      raise(5);
      chk("R8 lower held", {7'b0, int_req}, 8'h00);
      raise(1);
      chk("R8 higher passes", {7'b0, int_req}, 8'h01);
      wr(1'b0, 8'h0C);
      rd(1'b0, 8'h81, "R6 poll line 1");
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h0B);
      rd(1'b0, 8'h08, "R10 non-specific");
      wr(1'b0, 8'h63);
      rd(1'b0, 8'h00, "R10 specific");
      chk("R8 released", {7'b0, int_req}, 8'h01);
      wr(1'b0, 8'h0C);
      rd(1'b0, 8'h85, "R6 poll line 5");
   endtask

   task automatic t_special;
      raise(6);
      chk("R8 line 6 held", {7'b0, int_req}, 8'h00);
      wr(1'b0, 8'h48);
      chk("R5 bit6 ignored", {7'b0, int_req}, 8'h00);
      wr(1'b0, 8'h68);
      chk("R9 special mode", {7'b0, int_req}, 8'h01);
      wr(1'b0, 8'h0C);
      rd(1'b0, 8'h86, "R9 lower serviced");
      rd(1'b0, 8'h60, "R9 in-service pair");
      wr(1'b0, 8'h28);
      wr(1'b0, 8'h65);
      wr(1'b0, 8'h66);
      rd(1'b0, 8'h00, "R10 cleared");
   endtask

   task automatic t_mask_empty;
      wr(1'b1, 8'h80);
      rd(1'b1, 8'h80, "R11 mask read");
      raise(7);
      chk("R11 masked", {7'b0, int_req}, 8'h00);
      wr(1'b0, 8'h0C);
      rd(1'b0, 8'h00, "R7 empty poll");
      wr(1'b0, 8'h0A);
      rd(1'b0, 8'h80, "R7 pending kept");
      wr(1'b1, 8'h00);
      chk("R11 unmasked", {7'b0, int_req}, 8'h01);
      wr(1'b0, 8'h8C);
      rd(1'b0, 8'h80, "R2 bit7 rejected");
   endtask

   task automatic t_init;
      wr(1'b1, 8'h55);
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'h10);
      rd(1'b1, 8'h00, "R12 mask cleared");
      chk("R12 int_req", {7'b0, int_req}, 8'h00);
      raise(0);
      rd(1'b0, 8'h01, "R12 pending select");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select_poll();
      t_normal_eoi();
      t_special();
      t_mask_empty();
      t_init();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule